// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one timer channel that produces a pulse-width-modulated waveform. A counter advances once per prescaled tick. It runs upward from 1 and is compared against two active compare registers. The duty register sets where the pulse ends. The period register sets the last count of each cycle. After that last count the counter starts again at 1.

Software never writes the active registers directly. It writes shadow copies, and the channel moves the shadow values into the active registers only on the tick that ends a counter cycle. Every cycle is therefore built from one consistent pair of values.

Each period end sets a sticky flag. The flag is visible one clock after the ending tick and stays set until a clear request. An output-disable input parks the pin at the level of the polarity input. That level is also the pin's inactive level.

Top module: `pwm_buf_chan`

## Requirements
- R1: While reset is asserted, and directly at its release, `cnt_val` is 1, `flag` is 0 and `pwm_out` equals `edge_pol`. Reset also clears all four compare registers. The internal reset is released two clocks after `rst_n` rises.
- R2: Shadow writes never alter the active compare values in the middle of a cycle. A value written during a period is used from the following period on. A write on the same clock as a period end is used one period later.
- R3: The counter starts each period at 1 and counts up. On the tick where the count equals the active period value, it returns to 1. A period therefore spans that many ticks.
- R4: The 2-bit `div_sel` selects a tick every 1, 2, 3 or 4 clocks (codes 0 to 3). The counter holds between ticks. On the first clock where `div_sel` differs from its previous value, no tick occurs and the divide count restarts from zero.
- R5: With output disable low, `pwm_out` is at the active level (the inverse of `edge_pol`) while the count is below the active duty value, and at `edge_pol` otherwise. A duty value of 0 or 1 gives an all-inactive period. A duty value above the period value gives an all-active period.
- R6: `flag` becomes 1 on the clock edge where the counter returns to 1. It stays 1 until `flag_clr` is sampled high, and is 0 on the clock after that.
- R7: When `flag_clr` and a period end fall on the same clock, `flag` is 1 afterwards.
- R8: From the clock after `out_dis` is sampled high, `pwm_out` equals `edge_pol` for as long as `out_dis` stays high. The counter and the flag keep running. After release, the pin follows R5 again from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Tick divide select: code k gives a tick every k+1 clocks |
| edge_pol | input | 1 | Inactive and disabled pin level |
| out_dis | input | 1 | Forces the pin to `edge_pol` |
| duty_wr | input | 1 | Write strobe for the shadow duty register |
| duty_wdata | input | CNT_W | Shadow duty value |
| per_wr | input | 1 | Write strobe for the shadow period register |
| per_wdata | input | CNT_W | Shadow period value |
| flag_clr | input | 1 | Clears the period flag |
| pwm_out | output | 1 | PWM pin |
| flag | output | 1 | Sticky period-end flag |
| cnt_val | output | CNT_W | Current counter value |

## Verification
Two functions can fall on the same clock. A flag clear can coincide with a period end. A shadow write can coincide with the load of the active registers.

A one-clock period (period value 1 with divide-by-one) makes every clock a period end. In that setup the bench raises `flag_clr` and expects the flag to stay at 1. For longer periods it raises the clear just after a period end and expects 0 on the next clock.

The bench also writes a new duty value at the start of every period. It then judges that value from two sides. The current period must keep the old waveform. The first count of the next period must show the opposite level, as predicted from the new value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PS_W = 2;

  typedef enum logic [PS_W-1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY3 = 2'd2,
    DIV_BY4 = 2'd3
  } div_sel_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_t sel,
  output logic     tick
);

  div_sel_t        sel_q;
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] div_d;
  logic            sel_chg;

  always_comb begin
    sel_chg = (sel != sel_q);
    tick    = !sel_chg && (div_q == PS_W'(sel));
    if (sel_chg || tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= DIV_BY1;
      div_q <= '0;
    end else begin
      sel_q <= sel;
      div_q <= div_d;
    end
  end

  AST_DIV1_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == DIV_BY1 && $past(sel) == DIV_BY1) |-> tick); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != DIV_BY1) |=> !tick); // R4

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] duty_nxt,
  output logic             period_end
);

  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_sh_q, duty_sh_d;
  logic [CNT_W-1:0] per_sh_q, per_sh_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [CNT_W-1:0] per_q, per_d;

  always_comb begin
    period_end = tick && (cnt_q == per_q);
    duty_sh_d  = duty_wr ? duty_wdata : duty_sh_q;
    per_sh_d   = per_wr ? per_wdata : per_sh_q;
    duty_d     = period_end ? duty_sh_q : duty_q;
    per_d      = period_end ? per_sh_q : per_q;
    if (period_end) begin
      cnt_nxt = CNT_START;
    end else if (tick) begin
      cnt_nxt = cnt_q + CNT_W'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
    duty_nxt = duty_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_START;
      duty_sh_q <= '0;
      per_sh_q  <= '0;
      duty_q    <= '0;
      per_q     <= '0;
    end else begin
      cnt_q     <= cnt_nxt;
      duty_sh_q <= duty_sh_d;
      per_sh_q  <= per_sh_d;
      duty_q    <= duty_d;
      per_q     <= per_d;
    end
  end

  assign cnt      = cnt_q;
  assign duty_act = duty_q;

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(duty_q) && $stable(per_q))); // R2

  AST_RESTART_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt_q == CNT_START)); // R3

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             period_end,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] duty_nxt,
  input  logic             edge_pol,
  input  logic             out_dis,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             flag
);

  logic act_q, act_d;
  logic dis_q;
  logic flag_q, flag_d;

  always_comb begin
    act_d = tick ? (cnt_nxt < duty_nxt) : act_q;
    if (period_end) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dis_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      dis_q  <= out_dis;
      flag_q <= flag_d;
    end
  end

  assign pwm_out = dis_q ? edge_pol : (act_q ^ edge_pol);
  assign flag    = flag_q;

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R6

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !period_end) |=> !flag_q); // R6

endmodule

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       div_sel,
  input  logic             edge_pol,
  input  logic             out_dis,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             flag,
  output logic [CNT_W-1:0] cnt_val
);

  logic             rst_n_int;
  logic             tick;
  logic             period_end;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] duty_nxt;
  logic [CNT_W-1:0] duty_act;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pwm_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n_int),
    .sel   (div_sel_t'(div_sel)),
    .tick  (tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (tick),
    .duty_wr    (duty_wr),
    .duty_wdata (duty_wdata),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .cnt        (cnt_val),
    .duty_act   (duty_act),
    .cnt_nxt    (cnt_nxt),
    .duty_nxt   (duty_nxt),
    .period_end (period_end)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (tick),
    .period_end (period_end),
    .cnt_nxt    (cnt_nxt),
    .duty_nxt   (duty_nxt),
    .edge_pol   (edge_pol),
    .out_dis    (out_dis),
    .flag_clr   (flag_clr),
    .pwm_out    (pwm_out),
    .flag       (flag)
  );

  AST_PIN_FOLLOWS_COMPARE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$past(out_dis) |-> ((pwm_out != edge_pol) == (cnt_val < duty_act))); // R5

  AST_DISABLED_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_int)
    $past(out_dis) |-> (pwm_out == edge_pol)); // R8

  AST_FLAG_WITH_RESTART: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tick && cnt_val == cnt_nxt - CNT_W'(0) && period_end) |=> (flag && cnt_val == CNT_W'(1))); // R6

endmodule

// File: tb/sim_pwm_buf_chan.sv
module sim_pwm_buf_chan;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   div_sel;
  logic         edge_pol;
  logic         out_dis;
  logic         duty_wr;
  logic [W-1:0] duty_wdata;
  logic         per_wr;
  logic [W-1:0] per_wdata;
  logic         flag_clr;
  logic         pwm_out;
  logic         flag;
  logic [W-1:0] cnt_val;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  pwm_buf_chan #(.CNT_W(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .edge_pol   (edge_pol),
    .out_dis    (out_dis),
    .duty_wr    (duty_wr),
    .duty_wdata (duty_wdata),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .flag_clr   (flag_clr),
    .pwm_out    (pwm_out),
    .flag       (flag),
    .cnt_val    (cnt_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reset, load shadows, wait for the first period end that loads them.
  task automatic start_cfg(input bit pol, input int ps, input int per, input int duty);
    int guard;
    rst_n      = 1'b0;
    edge_pol   = pol;
    div_sel    = 2'(ps);
    out_dis    = 1'b0;
    flag_clr   = 1'b0;
    duty_wr    = 1'b0;
    per_wr     = 1'b0;
    duty_wdata = '0;
    per_wdata  = '0;
    @(negedge clk);
    chk(cnt_val == 1 && flag == 1'b0 && pwm_out == pol, "R1 reset state",
        {cnt_val, flag, pwm_out}, {4'd1, 1'b0, pol});
    @(negedge clk);
    rst_n = 1'b1;
    chk(cnt_val == 1 && flag == 1'b0 && pwm_out == pol, "R1 at release",
        {cnt_val, flag, pwm_out}, {4'd1, 1'b0, pol});
    @(negedge clk);
    @(negedge clk);
    duty_wr    = 1'b1;
    duty_wdata = W'(duty);
    per_wr     = 1'b1;
    per_wdata  = W'(per);
    @(negedge clk);
    duty_wr = 1'b0;
    per_wr  = 1'b0;
    // R2: active duty still zero, so the pin stays inactive mid-cycle
    chk(pwm_out == pol, "R2 no mid-cycle load", pwm_out, pol);
    guard = 0;
    while (!flag && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(flag == 1'b1, "R6 flag at first period end", flag, 1);
    chk(cnt_val == 1, "R3 restart at 1", cnt_val, 1);
  endtask

  task automatic run_cfg(input bit pol, input int ps, input int per, input int duty);
    int  pc;
    int  duty2;
    int  c;
    bit  eo;
    start_cfg(pol, ps, per, duty);
    pc    = per * (ps + 1);
    duty2 = (duty >= 2) ? 0 : per + 1;
    for (int k = 0; k < pc; k++) begin
      if (k > 0) begin
        @(negedge clk);
        flag_clr = 1'b0;
        duty_wr  = 1'b0;
        if (k == 1) chk(flag == 1'b0, "R6 flag cleared", flag, 0);
      end
      c  = 1 + k / (ps + 1);
      eo = (c < duty) ? !pol : pol;
      chk(cnt_val == W'(c), "R3 R4 count sequence", cnt_val, c);
      chk(pwm_out == eo, "R5 pin level", pwm_out, eo);
      if (k == 0) begin
        flag_clr = 1'b1;
        if (pc > 1) begin
          duty_wr    = 1'b1;
          duty_wdata = W'(duty2);
        end
      end
    end
    @(negedge clk);
    flag_clr = 1'b0;
    duty_wr  = 1'b0;
    chk(cnt_val == 1, "R3 wrap to 1", cnt_val, 1);
    if (pc == 1) begin
      chk(flag == 1'b1, "R7 set wins over clear", flag, 1);
    end else begin
      chk(flag == 1'b1, "R6 flag at period end", flag, 1);
      eo = (1 < duty2) ? !pol : pol;
      chk(pwm_out == eo, "R2 new duty next period", pwm_out, eo);
    end
  endtask

  task automatic test_disable(input bit pol);
    bit eo;
    start_cfg(pol, 0, 4, 3);
    out_dis = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(pwm_out == pol, "R8 disabled pin", pwm_out, pol);
    end
    chk(flag == 1'b1, "R8 flag keeps running", flag, 1);
    out_dis = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      eo = (cnt_val < 3) ? !pol : pol;
      chk(pwm_out == eo, "R8 resume after release", pwm_out, eo);
    end
  endtask

  task automatic test_div_change();
    start_cfg(1'b0, 3, 12, 0);
    @(negedge clk);
    @(negedge clk);
    div_sel = 2'd1;
    @(negedge clk);
    chk(cnt_val == 1, "R4 no tick on select change", cnt_val, 1);
    @(negedge clk);
    chk(cnt_val == 1, "R4 divide count restarted", cnt_val, 1);
    @(negedge clk);
    chk(cnt_val == 2, "R4 first tick after restart", cnt_val, 2);
    @(negedge clk);
    @(negedge clk);
    chk(cnt_val == 3, "R4 divide by two", cnt_val, 3);
  endtask

  initial begin
    for (int pol = 0; pol < 2; pol++) begin
      for (int ps = 0; ps < 4; ps++) begin
        for (int per = 1; per <= 5; per++) begin
          for (int duty = 0; duty <= per + 1; duty++) begin
            run_cfg(pol[0], ps, per, duty);
          end
        end
      end
    end
    test_disable(1'b0);
    test_disable(1'b1);
    test_div_change();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule